// File: doc/BRIEF.md
# A/D Conversion Control and Status Register

This block is the control and status register that sits between a CPU bus and an A/D converter core. Software uses it to choose a start source, to launch a conversion by software or let an external or timer trigger launch it, to watch whether a conversion is running, and to stop a running conversion. The converter core is seen only through strobes. The block sends one-cycle start and abort pulses to the core. The core returns a one-cycle "result stored" strobe.

Each stored result sets an end-of-conversion flag. When the enable bit is also set, the flag raises either an interrupt or a DMA request; a DMA-enable input picks which one. In single mode the busy flag drops by itself once the result is stored. In continuous mode it stays up until software writes 0 to it. Stop mode does the same, and in addition parks the core in a paused state after each result until the selected trigger fires again.

The register is one half-word with one byte-lane enable per byte. All control lives in the upper lane and the lower lane reads 0. A sideband input marks reads that belong to a read-modify-write cycle. Such reads return busy as 1, so that writing the value back cannot stop the converter.

Top module: `adc_ctl_reg`

## Requirements
- R1: After hardware reset every register bit reads 0, and `irq`, `dma_req`, `conv_start` and `conv_abort` are low. The read layout is: bit 15 busy, bit 14 end-of-conversion flag, bit 13 interrupt enable, bit 12 pause, bits 11:10 start source, bit 9 start (always reads 0), bit 8 reserved (reads 0), bits 7:0 read 0.
- R2: Two events start a conversion while the block is idle. The first is a write with byte lane 1 enabled, bit 15 = 1 and bit 9 = 1. The second is a selected trigger pulse; the source codes are 00 software only, 01 external, 10 timer, 11 either. In the cycle after the start, busy reads 1 and `conv_start` is high for exactly that one cycle.
- R3: A write with bit 15 = 0 and bit 9 = 1 never starts a conversion, whether the block is busy or idle.
- R4: A write with byte lane 1 enabled and bit 15 = 0 while busy aborts the conversion. In the next cycle busy and pause read 0 and `conv_abort` is high for one cycle.
- R5: In single mode (mode 00, and also the unused code 11), a `conv_done` strobe while busy clears busy in the next cycle.
- R6: In continuous mode (01), busy stays set after `conv_done`. In stop mode (10), busy stays set and pause sets. While paused, a selected trigger clears pause and pulses `conv_start`.
- R7: `conv_done` sets the end-of-conversion flag in the next cycle. If a clear arrives in the same cycle, the set wins.
- R8: The end-of-conversion flag is cleared by writing 0 to bit 14, or by a `dma_ack` pulse. Writing 1 to bit 14 has no effect.
- R9: `irq` equals flag AND enable AND NOT `dma_en`. `dma_req` equals flag AND enable AND `dma_en`.
- R10: A read with `rmw_rd` high returns bit 15 as 1 whatever the busy state.
- R11: A write with byte lane 1 disabled changes nothing.
- R12: `soft_rst` clears busy, the flag, the enable and pause, and pulses `conv_abort` if a conversion was running. The start source is kept.
- R13: While busy and not paused, a software start or a trigger produces no `conv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| rmw_rd | input | 1 | Current read is part of a read-modify-write |
| be | input | 2 | Byte-lane enables (bit 1 = control byte) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when `rd_en` is low |
| mode | input | 2 | Conversion mode: 00 single, 01 continuous, 10 stop |
| ext_trig | input | 1 | External trigger pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| conv_done | input | 1 | Core strobe: result stored |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_abort | output | 1 | One-cycle forced-stop pulse to the core |
| dma_en | input | 1 | Route the request to DMA instead of the interrupt |
| dma_ack | input | 1 | DMA transfer finished |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request level |

## Verification
The hardest state to reach from the ports is a stop-mode conversion that is busy and paused at the same time. Only in that state can a trigger restart the core without a new start, and only in that state does an abort also have to clear pause. The stimulus table gets there by selecting the timer source, starting from a timer pulse in stop mode, and delivering a result strobe. It then fires one trigger to resume and aborts with the prohibited bit-15/bit-9 combination. Directed tests then force same-cycle collisions: a result strobe against a flag-clearing write, and a repeated start against a running continuous conversion.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_CONT   = 2'b01,
    MODE_STOP   = 2'b10,
    MODE_SPARE  = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    SRC_SW  = 2'b00,
    SRC_EXT = 2'b01,
    SRC_TMR = 2'b10,
    SRC_ANY = 2'b11
  } start_src_e;

  // bit positions inside the control byte (top lane)
  localparam int unsigned CB_BUSY  = 7;
  localparam int unsigned CB_FLAG  = 6;
  localparam int unsigned CB_IE    = 5;
  localparam int unsigned CB_PAUSE = 4;
  localparam int unsigned CB_SRCH  = 3;
  localparam int unsigned CB_SRCL  = 2;
  localparam int unsigned CB_GO    = 1;

  typedef struct packed {
    logic       cfg_wr;
    logic       abort_wr;
    logic       sw_start;
    logic       flag_clr;
    logic       ie_val;
    start_src_e src_val;
  } wr_cmd_t;

endpackage

// File: rtl/adc_bus_dec.sv
module adc_bus_dec
  import adc_ctl_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic                 wr_en,
  input  logic [BUS_W/8-1:0]   be,
  input  logic [BUS_W-1:0]     wdata,
  output wr_cmd_t              cmd
);
  localparam int unsigned NLANE = BUS_W / 8;

  logic       hit;
  logic [7:0] cb;
  logic       lane_unused;

  assign hit = wr_en && be[NLANE-1];
  assign cb  = wdata[BUS_W-1 -: 8];
  assign lane_unused = ^{be[NLANE-2:0], wdata[BUS_W-9:0], cb[0], cb[CB_PAUSE]};

  always_comb begin
    cmd          = '0;
    cmd.cfg_wr   = hit;
    cmd.abort_wr = hit && !cb[CB_BUSY];
    // prohibited busy=0 + go=1: termination only, never a start
    cmd.sw_start = hit && cb[CB_BUSY] && cb[CB_GO];
    cmd.flag_clr = hit && !cb[CB_FLAG];
    cmd.ie_val   = cb[CB_IE];
    cmd.src_val  = start_src_e'(cb[CB_SRCH:CB_SRCL]);
  end

  // R3
  always_comb begin
    no_start_on_abort_chk: assert (!(cmd.abort_wr && cmd.sw_start));
  end

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_wr,
  input  start_src_e src_val,
  input  logic       soft_rst,
  input  logic       ext_trig,
  input  logic       tmr_trig,
  output start_src_e src,
  output logic       hw_trig
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src <= SRC_SW;
    else if (src_wr) src <= src_val;
  end

  always_comb begin
    unique case (src)
      SRC_EXT: hw_trig = ext_trig;
      SRC_TMR: hw_trig = tmr_trig;
      SRC_ANY: hw_trig = ext_trig || tmr_trig;
      default: hw_trig = 1'b0;
    endcase
  end

  // R12
  src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !src_wr |=> $stable(src));

  // R2
  sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src == SRC_SW |-> !hw_trig);

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  conv_mode_e mode,
  input  logic       sw_start,
  input  logic       abort_wr,
  input  logic       hw_trig,
  input  logic       conv_done,
  output logic       busy,
  output logic       pause,
  output logic       conv_start,
  output logic       conv_abort
);
  logic start_ok, resume;

  assign start_ok = !busy && (sw_start || hw_trig) && !abort_wr;
  assign resume   = busy && pause && hw_trig && !abort_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pause      <= 1'b0;
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
      if (soft_rst) begin
        busy       <= 1'b0;
        pause      <= 1'b0;
        conv_abort <= busy;
      end else if (abort_wr && busy) begin
        busy       <= 1'b0;
        pause      <= 1'b0;
        conv_abort <= 1'b1;
      end else if (start_ok) begin
        busy       <= 1'b1;
        pause      <= 1'b0;
        conv_start <= 1'b1;
      end else if (resume) begin
        pause      <= 1'b0;
        conv_start <= 1'b1;
      end else if (conv_done && busy) begin
        unique case (mode)
          MODE_CONT: ;
          MODE_STOP: pause <= 1'b1;
          default:   busy  <= 1'b0;
        endcase
      end
    end
  end

  // R4
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr && busy && !soft_rst |=> !busy && !pause && conv_abort);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done && (mode == MODE_SINGLE) && !pause && !abort_wr && !soft_rst
    |=> !busy);

  // R6
  stop_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && conv_done && (mode == MODE_STOP) && !pause && !abort_wr && !soft_rst
    |=> busy && pause);

  // R13
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !pause |=> !conv_start);

  // R12
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy && !pause && !conv_start);

endmodule

// File: rtl/adc_flag.sv
module adc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic conv_done,
  input  logic flag_clr,
  input  logic dma_ack,
  input  logic cfg_wr,
  input  logic ie_val,
  input  logic dma_en,
  output logic eoc,
  output logic ie,
  output logic irq,
  output logic dma_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc <= 1'b0;
      ie  <= 1'b0;
    end else if (soft_rst) begin
      eoc <= 1'b0;
      ie  <= 1'b0;
    end else begin
      if (conv_done)                eoc <= 1'b1;
      else if (flag_clr || dma_ack) eoc <= 1'b0;
      if (cfg_wr) ie <= ie_val;
    end
  end

  assign irq     = eoc && ie && !dma_en;
  assign dma_req = eoc && ie && dma_en;

  // R7
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !soft_rst |=> eoc);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack && !conv_done && !soft_rst |=> !eoc);

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));

  // R9
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || dma_req) |-> eoc && ie);

endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_ctl_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               rmw_rd,
  input  logic [BUS_W/8-1:0] be,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  input  logic [1:0]         mode,
  input  logic               ext_trig,
  input  logic               tmr_trig,
  input  logic               conv_done,
  output logic               conv_start,
  output logic               conv_abort,
  input  logic               dma_en,
  input  logic               dma_ack,
  output logic               irq,
  output logic               dma_req
);
  localparam int unsigned LOW_W = BUS_W - 8;

  wr_cmd_t    cmd;
  start_src_e src;
  logic       hw_trig, busy, pause, eoc, ie;

  adc_bus_dec #(.BUS_W(BUS_W)) u_dec (
    .wr_en (wr_en),
    .be    (be),
    .wdata (wdata),
    .cmd   (cmd)
  );

  adc_trig_sel u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_wr   (cmd.cfg_wr),
    .src_val  (cmd.src_val),
    .soft_rst (soft_rst),
    .ext_trig (ext_trig),
    .tmr_trig (tmr_trig),
    .src      (src),
    .hw_trig  (hw_trig)
  );

  adc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .mode       (conv_mode_e'(mode)),
    .sw_start   (cmd.sw_start),
    .abort_wr   (cmd.abort_wr),
    .hw_trig    (hw_trig),
    .conv_done  (conv_done),
    .busy       (busy),
    .pause      (pause),
    .conv_start (conv_start),
    .conv_abort (conv_abort)
  );

  adc_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .conv_done (conv_done),
    .flag_clr  (cmd.flag_clr),
    .dma_ack   (dma_ack),
    .cfg_wr    (cmd.cfg_wr),
    .ie_val    (cmd.ie_val),
    .dma_en    (dma_en),
    .eoc       (eoc),
    .ie        (ie),
    .irq       (irq),
    .dma_req   (dma_req)
  );

  always_comb begin
    rdata = '0;
    if (rd_en)
      rdata = {busy || rmw_rd, eoc, ie, pause, src, 1'b0, 1'b0, {LOW_W{1'b0}}};
  end

  // R10
  rmw_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rmw_rd |-> rdata[BUS_W-1]);

  // R1
  go_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-7:0] == '0);

  // R11
  lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !be[BUS_W/8-1] && !soft_rst |=> $stable(src) && $stable(ie));

endmodule

// File: tb/adc_ctl_reg_bench.sv
`timescale 1ns/1ps
module adc_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, wr_en, rd_en, rmw_rd;
  logic [1:0]  be, mode;
  logic [15:0] wdata, rdata;
  logic        ext_trig, tmr_trig, conv_done, conv_start, conv_abort;
  logic        dma_en, dma_ack, irq, dma_req;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  adc_ctl_reg u_adc_ctl_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .rd_en(rd_en),
    .rmw_rd(rmw_rd), .be(be), .wdata(wdata), .rdata(rdata), .mode(mode),
    .ext_trig(ext_trig), .tmr_trig(tmr_trig), .conv_done(conv_done),
    .conv_start(conv_start), .conv_abort(conv_abort), .dma_en(dma_en),
    .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req)
  );

  // kind: 0 write, 1 done, 2 dma_ack, 3 ext trig, 4 timer trig, 5 soft reset
  // fields: kind[40:38] mode[37:36] be[35:34] wdata[33:18] exp_rd[17:2] start[1] abort[0]
  localparam int NV = 20;
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 2'b00, 2'b10, 16'h2000, 16'h2000, 1'b0, 1'b0}, // R11 setup: enable
    {3'd0, 2'b00, 2'b10, 16'hA200, 16'hA000, 1'b1, 1'b0}, // R2 sw start
    {3'd1, 2'b00, 2'b00, 16'h0000, 16'h6000, 1'b0, 1'b0}, // R5 R7 single done
    {3'd2, 2'b00, 2'b00, 16'h0000, 16'h2000, 1'b0, 1'b0}, // R8 dma ack
    {3'd0, 2'b00, 2'b01, 16'h0000, 16'h2000, 1'b0, 1'b0}, // R11 low lane only
    {3'd0, 2'b01, 2'b10, 16'h2400, 16'h2400, 1'b0, 1'b0}, // src ext
    {3'd3, 2'b01, 2'b00, 16'h0000, 16'hA400, 1'b1, 1'b0}, // R2 ext trig
    {3'd1, 2'b01, 2'b00, 16'h0000, 16'hE400, 1'b0, 1'b0}, // R6 continuous
    {3'd0, 2'b01, 2'b10, 16'h6400, 16'h6400, 1'b0, 1'b1}, // R4 abort
    {3'd0, 2'b01, 2'b10, 16'h2400, 16'h2400, 1'b0, 1'b0}, // R8 write clear
    {3'd0, 2'b10, 2'b10, 16'h2800, 16'h2800, 1'b0, 1'b0}, // src timer
    {3'd3, 2'b10, 2'b00, 16'h0000, 16'h2800, 1'b0, 1'b0}, // R2 unselected trig
    {3'd4, 2'b10, 2'b00, 16'h0000, 16'hA800, 1'b1, 1'b0}, // R2 timer trig
    {3'd1, 2'b10, 2'b00, 16'h0000, 16'hF800, 1'b0, 1'b0}, // R6 stop pause
    {3'd4, 2'b10, 2'b00, 16'h0000, 16'hE800, 1'b1, 1'b0}, // R6 resume
    {3'd0, 2'b10, 2'b10, 16'h6A00, 16'h6800, 1'b0, 1'b1}, // R3 R4 busy abort
    {3'd0, 2'b00, 2'b10, 16'h6A00, 16'h6800, 1'b0, 1'b0}, // R3 idle no start
    {3'd0, 2'b00, 2'b10, 16'h2C00, 16'h2C00, 1'b0, 1'b0}, // src any
    {3'd0, 2'b00, 2'b10, 16'hEE00, 16'hAC00, 1'b1, 1'b0}, // R8 write-1 no effect
    {3'd5, 2'b00, 2'b00, 16'h0000, 16'h0C00, 1'b0, 1'b1}  // R12 soft reset
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    soft_rst = 0; wr_en = 0; rd_en = 0; rmw_rd = 0; be = 2'b00; wdata = '0;
    ext_trig = 0; tmr_trig = 0; conv_done = 0; dma_ack = 0;
  endtask

  // drive at negedge, one posedge, sample pulses at next negedge
  task automatic step(input logic [2:0] kind, input logic [1:0] bes, input logic [15:0] wd,
                      output logic st, output logic ab);
    case (kind)
      3'd0: begin wr_en = 1; be = bes; wdata = wd; end
      3'd1: conv_done = 1;
      3'd2: dma_ack = 1;
      3'd3: ext_trig = 1;
      3'd4: tmr_trig = 1;
      default: soft_rst = 1;
    endcase
    @(negedge clk);
    st = conv_start; ab = conv_abort;
    idle_inputs();
  endtask

  task automatic rd(input logic rmw, output logic [15:0] v);
    rd_en = 1; rmw_rd = rmw; #1; v = rdata; rd_en = 0; rmw_rd = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic st, ab;
    logic [15:0] v;
    idle_inputs(); mode = 2'b00; dma_en = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(1'b0, v);
    check("R1 reset read", v, 16'h0000);
    check("R1 reset outs", {12'h0, irq, dma_req, conv_start, conv_abort}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][37:36];
      step(VEC[i][40:38], VEC[i][35:34], VEC[i][33:18], st, ab);
      rd(1'b0, v);
      check($sformatf("vec%0d read R2..R13", i), v, VEC[i][17:2]);
      check($sformatf("vec%0d conv_start R2 R6", i), {15'h0, st}, {15'h0, VEC[i][1]});
      check($sformatf("vec%0d conv_abort R4 R12", i), {15'h0, ab}, {15'h0, VEC[i][0]});
    end

    // R1 R10: hard reset, then read-modify-write read while idle
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(1'b0, v);
    check("R1 reset clears src", v, 16'h0000);
    rd(1'b1, v);
    check("R10 rmw busy", v, 16'h8000);

    // R9 request routing
    mode = 2'b00;
    step(3'd0, 2'b10, 16'hA200, st, ab);
    check("R2 start pulse", {15'h0, st}, 16'h0001);
    step(3'd1, 2'b00, 16'h0, st, ab);
    check("R9 irq", {14'h0, irq, dma_req}, 16'h0002);
    dma_en = 1; #1;
    check("R9 dma_req", {14'h0, irq, dma_req}, 16'h0001);
    step(3'd2, 2'b00, 16'h0, st, ab);
    check("R8 dma ack clears", {14'h0, irq, dma_req}, 16'h0000);
    dma_en = 0;

    // R7 same-cycle done and flag-clear write: set wins
    step(3'd0, 2'b10, 16'hA200, st, ab);
    wr_en = 1; be = 2'b10; wdata = 16'hA000; conv_done = 1;
    @(negedge clk); idle_inputs();
    rd(1'b0, v);
    check("R7 set beats clear", v, 16'h6000);

    // R13 restart ignored while running in continuous mode
    mode = 2'b01;
    step(3'd0, 2'b10, 16'hE200, st, ab);
    check("R13 first start", {15'h0, st}, 16'h0001);
    step(3'd0, 2'b10, 16'hE200, st, ab);
    check("R13 restart ignored", {15'h0, st}, 16'h0000);
    rd(1'b0, v);
    check("R13 still busy", v, 16'hE000);
    step(3'd0, 2'b10, 16'h6000, st, ab);
    check("R4 abort continuous", {15'h0, ab}, 16'h0001);

    // R8 write 1 to flag bit when flag clear
    step(3'd0, 2'b10, 16'h2000, st, ab);
    step(3'd0, 2'b10, 16'h4000, st, ab);
    rd(1'b0, v);
    check("R8 write one no set", v, 16'h0000);

    finish_run();
  end
endmodule